// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a producer and a consumer that each own a free-running clock. The two clocks may be fully independent or may be the same net. Each port is qualified by two enables. On the write side, the second enable doubles as a mode select. When it is high, a strobe writes a data word. When it is low, the same strobe instead loads one byte of the threshold registers. The depth is a parameter and may be 64, 256, 512, 1024, 2048, 4096 or 8192.

Pointers cross between the clock domains as Gray code through two-flop synchronizers. Emptiness is judged in the read domain and fullness in the write domain. All four status flags are active low. The read data is held in a register and is gated by an active-low output enable. When that enable is off, the output reads as all zeros.

A synchronous active-high reset clears both pointers, the flags and the load sequence. It must be held for at least two edges of each clock.

Top module: `dcfifo_pflag`

## Requirements
- R1: After reset, empty_n=0, full_n=1, aempty_n=0, afull_n=1, dout=0, and both threshold offsets equal 7.
- R2: A word is stored on a rising clk_w edge only when wr_stb_n=0 and wr_mode=1. Any cycle with wr_stb_n=1 stores nothing. A cycle with wr_stb_n=0 and wr_mode=0 stores nothing either.
- R3: A word is read on a rising clk_r edge only when rd_stb_n=0 and rd_gate_n=0. Words leave in the order they were written. The word appears on dout just after the read edge. Between reads, dout holds its value.
- R4: empty_n is 0 whenever the read domain sees no stored words. A write becomes visible on empty_n after the second clk_r edge following the write edge. A read that takes the last word drops empty_n right after that read edge.
- R5: full_n is 0 when DEPTH words are held. A write attempted while full is dropped and does not disturb the stored words.
- R6: A read attempted while empty is dropped. dout keeps its value and the read pointer does not move.
- R7: aempty_n is 0 exactly when the word count is less than or equal to the almost-empty offset.
- R8: afull_n is 0 exactly when the word count plus the almost-full offset is at least DEPTH.
- R9: Each clk_w cycle with wr_stb_n=0 and wr_mode=0 loads din[7:0] into the next slot of a four-step cycle. The order is almost-empty bits 7:0, almost-empty bits 15:8, almost-full bits 7:0, then almost-full bits 15:8. After the fourth step the cycle wraps back to the first.
- R10: While out_en_n=1, dout is 0. The registered read word is still kept and shows again once out_en_n=0.
- R11: A read and a write in the same cycle both take effect and keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, applied in both domains |
| wr_stb_n | input | 1 | Active-low write/load strobe |
| wr_mode | input | 1 | 1 = store data word, 0 = load offset byte |
| din | input | DATA_W | Write data; bits 7:0 also carry offset bytes |
| rd_stb_n | input | 1 | First active-low read enable |
| rd_gate_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable for dout |
| dout | output | DATA_W | Registered read data, zero while disabled |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low at or below the almost-empty offset |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low within the almost-full offset of full |

## Verification
The FIFO is filled one word at a time from empty to full and then drained back to empty. All four flags are compared against arithmetic expectations at every occupancy. This is done once with the reset offsets and once with reprogrammed offsets, which separates off-by-one errors in the threshold comparisons from errors in the load order. Single-word writes are sampled cycle by cycle to pin down the synchronizer latency. Enable patterns with only one enable active, overflow attempts and underflow attempts show that blocked accesses leave the data and pointers untouched. A phase of simultaneous reads and writes, with the FIFO neither empty nor full, confirms that ordering holds under concurrent traffic.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int PART_W = 8;
  localparam int OFS_W  = 2 * PART_W;
  localparam logic [OFS_W-1:0] OFS_RESET = OFS_W'(7);

  typedef enum logic [1:0] {
    LD_AE_LO = 2'd0,
    LD_AE_HI = 2'd1,
    LD_AF_LO = 2'd2,
    LD_AF_HI = 2'd3
  } ld_slot_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] ram [WORDS];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb_n,
  input  logic              wr_mode,
  input  logic [PART_W-1:0] ld_byte,
  input  logic [AW:0]       rgray_s,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [AW:0]       wgray,
  output logic              full_n,
  output logic              afull_n,
  output logic [OFS_W-1:0]  ae_ofs
);
  localparam int SUM_W = OFS_W + 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0]      wbin, rbin_s, wcount, wbin_nxt;
  logic [OFS_W-1:0] af_ofs;
  ld_slot_e         slot;
  logic             wr_req, ld_req, full;

  assign wr_req = !wr_stb_n && wr_mode;
  assign ld_req = !wr_stb_n && !wr_mode;

  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign wcount   = wbin - rbin_s;
  assign full     = (wcount == FULL_CNT);
  assign we       = wr_req && !full;
  assign waddr    = wbin[AW-1:0];
  assign wbin_nxt = wbin + 1'b1;
  assign full_n   = !full;
  assign afull_n  = !((SUM_W'(wcount) + SUM_W'(af_ofs)) >= SUM_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= LD_AE_LO;
      ae_ofs <= OFS_RESET;
      af_ofs <= OFS_RESET;
    end else if (ld_req) begin
      case (slot)
        LD_AE_LO: ae_ofs[PART_W-1:0]     <= ld_byte;
        LD_AE_HI: ae_ofs[OFS_W-1:PART_W] <= ld_byte;
        LD_AF_LO: af_ofs[PART_W-1:0]     <= ld_byte;
        default:  af_ofs[OFS_W-1:PART_W] <= ld_byte;
      endcase
      slot <= ld_slot_e'(slot + 2'd1);
    end
  end

  // R5: occupancy seen by the writer never exceeds the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    wcount <= FULL_CNT);
  // R5: a write request at full leaves the write pointer where it was
  a_r5_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req) |=> $stable(wbin));
  // R2: the published Gray pointer moves by at most one bit per edge
  a_r2_gray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R8: full always implies almost-full
  a_r8_full_in_afull: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !afull_n);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_stb_n,
  input  logic             rd_gate_n,
  input  logic [AW:0]      wgray_s,
  input  logic [OFS_W-1:0] ae_ofs,
  output logic             re,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rgray,
  output logic             empty_n,
  output logic             aempty_n
);
  localparam int SUM_W = OFS_W + 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0] rbin, wbin_s, rcount, rbin_nxt;
  logic        rd_req, empty;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign rd_req   = !rd_stb_n && !rd_gate_n;
  assign rcount   = wbin_s - rbin;
  assign empty    = (rcount == '0);
  assign re       = rd_req && !empty;
  assign raddr    = rbin[AW-1:0];
  assign rbin_nxt = rbin + 1'b1;
  assign empty_n  = !empty;
  assign aempty_n = !(SUM_W'(rcount) <= SUM_W'(ae_ofs));

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (re) begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  // R6: occupancy seen by the reader never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    rcount <= FULL_CNT);
  // R6: a read request while empty leaves the read pointer where it was
  a_r6_hold_when_empty: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> $stable(rbin));
  // R7: empty always implies almost-empty
  a_r7_empty_in_aempty: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !aempty_n);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcfifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 9
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst,
  input  logic              wr_stb_n,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_stb_n,
  input  logic              rd_gate_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              full_n,
  output logic              afull_n
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              we, re;
  logic [OFS_W-1:0]  ae_ofs;
  logic [DATA_W-1:0] q_reg;

  dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk(clk_w), .rst(rst), .wr_stb_n(wr_stb_n), .wr_mode(wr_mode),
    .ld_byte(din[PART_W-1:0]), .rgray_s(rgray_s), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n), .ae_ofs(ae_ofs)
  );

  dcfifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk(clk_r), .rst(rst), .rd_stb_n(rd_stb_n), .rd_gate_n(rd_gate_n),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .re(re), .raddr(raddr),
    .rgray(rgray), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  dcfifo_sync #(.W(AW+1)) u_w2r (.clk(clk_r), .rst(rst), .d(wgray), .q(wgray_s));
  dcfifo_sync #(.W(AW+1)) u_r2w (.clk(clk_w), .rst(rst), .d(rgray), .q(rgray_s));

  dcfifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk(clk_w), .we(we), .waddr(waddr), .wdata(din),
    .rclk(clk_r), .rst(rst), .re(re), .raddr(raddr), .rdata(q_reg)
  );

  assign dout = out_en_n ? '0 : q_reg;
endmodule

// File: tb/dcfifo_pflag_test.sv
module dcfifo_pflag_test;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, wr_stb_n, wr_mode, rd_stb_n, rd_gate_n, out_en_n;
  logic [DW-1:0] din, dout;
  logic          empty_n, aempty_n, full_n, afull_n;

  int n_chk = 0, n_fail = 0;
  int ae = 7, af = 7;
  logic [DW-1:0] mq [256];
  int qh = 0, qt = 0;
  logic [DW-1:0] last_out;

  dcfifo_pflag #(.DEPTH(DEPTH), .DATA_W(DW)) uut (
    .clk_w(clk), .clk_r(clk), .rst(rst), .wr_stb_n(wr_stb_n), .wr_mode(wr_mode),
    .din(din), .rd_stb_n(rd_stb_n), .rd_gate_n(rd_gate_n), .out_en_n(out_en_n),
    .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n), .full_n(full_n),
    .afull_n(afull_n)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (3) cyc();
  endtask

  function automatic int count();
    return qt - qh;
  endfunction

  task automatic chk_flags(string req);
    int c = count();
    check({req, " empty_n"},  int'(empty_n),  int'(c != 0));
    check({req, " full_n"},   int'(full_n),   int'(c != DEPTH));
    check({req, " aempty_n"}, int'(aempty_n), int'(!(c <= ae)));
    check({req, " afull_n"},  int'(afull_n),  int'(!(c + af >= DEPTH)));
  endtask

  task automatic push(logic [DW-1:0] v);
    wr_stb_n = 1'b0; wr_mode = 1'b1; din = v;
    cyc();
    wr_stb_n = 1'b1;
    if (count() < DEPTH) begin mq[qt & 255] = v; qt++; end
  endtask

  task automatic pop_chk(string req);
    rd_stb_n = 1'b0; rd_gate_n = 1'b0;
    cyc();
    rd_stb_n = 1'b1; rd_gate_n = 1'b1;
    if (count() > 0) begin
      check(req, int'(dout), int'(mq[qh & 255]));
      last_out = mq[qh & 255];
      qh++;
    end else begin
      check(req, int'(dout), int'(last_out));
    end
  endtask

  task automatic load(logic [DW-1:0] v);
    wr_stb_n = 1'b0; wr_mode = 1'b0; din = v;
    cyc();
    wr_stb_n = 1'b1; wr_mode = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; wr_stb_n = 1'b1; wr_mode = 1'b1; rd_stb_n = 1'b1;
    rd_gate_n = 1'b1; out_en_n = 1'b0; din = '0; last_out = '0;
    repeat (4) cyc();
    rst = 1'b0;
    cyc();
    // R1: reset state
    chk_flags("R1");
    check("R1 dout", int'(dout), 0);

    // R2: blocked write patterns store nothing
    wr_stb_n = 1'b1; wr_mode = 1'b1; din = 9'h1FF; cyc();
    wr_mode = 1'b0; cyc();
    wr_mode = 1'b1;
    settle();
    check("R2 no store", int'(empty_n), 0);

    // R4: write visibility latency on empty_n
    push(9'h123);
    check("R4 after write edge", int'(empty_n), 0);
    cyc();
    check("R4 after sync1", int'(empty_n), 0);
    cyc();
    check("R4 after sync2", int'(empty_n), 1);
    pop_chk("R3 single word");
    check("R4 drop on last read", int'(empty_n), 0);

    // R3: one read enable alone does not read
    push(9'h0AB); settle();
    rd_stb_n = 1'b0; rd_gate_n = 1'b1; cyc();
    check("R3 only first enable", int'(dout), 9'h123);
    rd_stb_n = 1'b1; rd_gate_n = 1'b0; cyc();
    rd_gate_n = 1'b1;
    check("R3 only second enable", int'(dout), 9'h123);
    check("R3 word kept", int'(empty_n), 1);
    pop_chk("R3 read after blocked");

    // R7 R8: fill sweep with default offsets
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'((i * 37 + 5) & 9'h1FF)); settle(); chk_flags("R7 R8 fill");
    end
    // R5: write at full is dropped
    push(9'h1AA); settle();
    chk_flags("R5 full");
    for (int i = 0; i < DEPTH; i++) begin
      pop_chk("R5 R3 drain order"); settle(); chk_flags("R7 R8 drain");
    end

    // R6: read while empty
    pop_chk("R6 hold dout");
    settle(); chk_flags("R6 still empty");
    push(9'h155); settle();
    pop_chk("R6 no underflow");

    // R10: output enable
    push(9'h0F3); settle();
    out_en_n = 1'b1;
    rd_stb_n = 1'b0; rd_gate_n = 1'b0; cyc();
    rd_stb_n = 1'b1; rd_gate_n = 1'b1;
    qh++;
    check("R10 disabled", int'(dout), 0);
    out_en_n = 1'b0; #1;
    check("R10 enabled", int'(dout), 9'h0F3);
    last_out = 9'h0F3;
    settle(); chk_flags("R10 state");

    // R9: program offsets ae=3 af=10
    load(9'd3); load(9'd0); load(9'd10); load(9'd0);
    ae = 3; af = 10;
    settle();
    check("R9 R2 load stores nothing", int'(empty_n), 0);
    for (int i = 0; i < DEPTH; i++) begin
      push(DW'((i * 11 + 2) & 9'h1FF)); settle(); chk_flags("R9 fill");
    end
    for (int i = 0; i < DEPTH; i++) begin
      pop_chk("R9 drain"); settle(); chk_flags("R9 drain");
    end

    // R9: wrap of the load sequence
    load(9'd20); load(9'd0); load(9'd2); load(9'd0); load(9'd1);
    ae = 1; af = 2;
    push(9'h011); settle(); chk_flags("R9 wrap c1");
    push(9'h022); settle(); chk_flags("R9 wrap c2");
    pop_chk("R9 wrap drain"); pop_chk("R9 wrap drain");
    settle(); chk_flags("R9 wrap empty");

    // R11: concurrent read and write stream
    for (int i = 0; i < 4; i++) push(DW'(9'h100 + i));
    settle();
    for (int j = 0; j < 20; j++) begin
      wr_stb_n = 1'b0; wr_mode = 1'b1; din = DW'((j * 23 + 7) & 9'h1FF);
      rd_stb_n = 1'b0; rd_gate_n = 1'b0;
      cyc();
      wr_stb_n = 1'b1; rd_stb_n = 1'b1; rd_gate_n = 1'b1;
      check("R11 concurrent order", int'(dout), int'(mq[qh & 255]));
      last_out = mq[qh & 255];
      qh++;
      mq[qt & 255] = DW'((j * 23 + 7) & 9'h1FF); qt++;
    end
    settle(); chk_flags("R11 count");
    while (count() > 0) pop_chk("R11 drain");
    settle(); chk_flags("R11 empty");

    summary();
    $finish;
  end
endmodule